// File: doc/BRIEF.md
# Framed SPI Command Slave

This block is a serial slave that takes one 16-bit command per select window. The select is active low and the serial clock is sampled on its rising edge. In the same window the block returns a status word from the host logic. The select, serial clock and data-in pins are brought into the system clock domain through multi-flop synchronizers, and every edge is detected in that domain. The status word is captured when select falls and is then sent out most-significant bit first. A received word reaches the parallel side only when select is released, and only after exactly sixteen clock rising edges in that window.

Each accepted word is presented with a one-cycle strobe and then decoded. The top four bits form an opcode and the lower twelve bits form an argument. Opcodes with the top bit set write the argument into one of eight held slots, which keep their value across later frames. Opcodes with the top bit clear raise one of eight one-hot momentary lines and publish the argument. A momentary line stays up only until the next accepted command.

Top module: `spi_cmd_slave`

## Requirements
- R1: `miso_oe` is high only while select is low, as seen through the synchronizer. It returns low after select is released.
- R2: When select falls, `status_in` is captured. `miso` then shows status bit 15. After the k-th serial clock rising edge of the frame, `miso` shows status bit 15-k, and it shows 0 once k reaches 16 or more.
- R3: `mosi` is shifted in most-significant bit first. When select rises after exactly 16 rising edges, `cmd_word` takes the received word and `cmd_valid` is high for exactly one system clock.
- R4: A frame with fewer or more than 16 rising edges gives no strobe. It leaves `cmd_word`, `held_data`, `mom_out` and `mom_arg` unchanged. The edge count saturates, so a frame of 48 edges is also rejected.
- R5: Serial clock and data activity while select is high produces no strobe, keeps `miso_oe` low and changes no output.
- R6: The opcode is bits 15:12. If bit 15 is 1, the command is latched: held slot n (n = bits 14:12) receives bits 11:0 at `held_data[n*12 +: 12]`, and that value persists through later commands to other slots or of the other kind.
- R7: If bit 15 is 0, the command is momentary: `mom_out` becomes one-hot with bit n = bits 14:12 set, and `mom_arg` receives bits 11:0. The line stays set until the next accepted command. A later momentary command replaces it, and a later latched command clears `mom_out` to zero.
- R8: After reset, `cmd_word`, `cmd_valid`, `held_data`, `mom_out`, `mom_arg` and `miso_oe` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ss_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock, sampled on rising edges |
| mosi | input | 1 | Serial command data in |
| miso | output | 1 | Serial status data out |
| miso_oe | output | 1 | Output enable for the external tristate driver of `miso` |
| status_in | input | 16 | Status word loaded at frame start |
| cmd_word | output | 16 | Last accepted command word |
| cmd_valid | output | 1 | One-cycle strobe for an accepted command |
| held_data | output | 96 | Eight 12-bit held slots, slot n at bits n*12 +: 12 |
| mom_out | output | 8 | One-hot momentary command lines |
| mom_arg | output | 12 | Argument of the current momentary command |

## Verification
Any pin change takes two system clocks to clear the synchronizer. One more clock registers its effect. So `miso_oe` follows select after two clocks, the status bit on `miso` follows a select fall or a serial clock rise after three, and `cmd_valid` is high during exactly the third clock after select rises. The bench drives the pins on falling system clock edges. It waits three rising edges and samples on the next falling edge, which lands inside that window. It samples `cmd_valid` once there and once a clock later to prove the strobe is a single cycle. Every serial phase is held for four clocks, so each pin change is fully synchronized before the next one arrives.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  typedef enum logic {
    KIND_MOMENTARY = 1'b0,
    KIND_LATCHED   = 1'b1
  } cmd_kind_e;

  // Saturating increment used by the frame edge counter.
  function automatic int sat_inc(input int value, input int ceiling);
    return (value >= ceiling) ? ceiling : value + 1;
  endfunction

  // The most significant opcode bit selects the command kind.
  function automatic cmd_kind_e kind_of(input logic op_msb);
    return op_msb ? KIND_LATCHED : KIND_MOMENTARY;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ss_n,
  input  logic              sclk,
  input  logic              mosi,
  input  logic [WORD_W-1:0] status_in,
  output logic              miso,
  output logic              miso_oe,
  output logic              frame_ok,
  output logic [WORD_W-1:0] frame_word
);

  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic ss_s, sclk_s, mosi_s;
  logic ss_prev, sclk_prev;
  logic sel_fall, sel_rise, sclk_rise, in_frame;
  logic [WORD_W-1:0] rx_sr, tx_sr;
  logic [CNT_W-1:0]  edge_cnt;

  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
    .clk(clk), .rst_n(rst_n), .d(ss_n), .q(ss_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk(clk), .rst_n(rst_n), .d(mosi), .q(mosi_s));

  // Named edge events, visible to the assertions below.
  assign in_frame  = ~ss_s;
  assign sel_fall  = ss_prev & ~ss_s;
  assign sel_rise  = ~ss_prev & ss_s;
  assign sclk_rise = ~sclk_prev & sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_prev   <= 1'b1;
      sclk_prev <= 1'b0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      edge_cnt  <= '0;
    end else begin
      ss_prev   <= ss_s;
      sclk_prev <= sclk_s;
      if (sel_fall) begin
        tx_sr    <= status_in;
        edge_cnt <= '0;
      end else if (sclk_rise && in_frame) begin
        rx_sr    <= {rx_sr[WORD_W-2:0], mosi_s};
        tx_sr    <= {tx_sr[WORD_W-2:0], 1'b0};
        edge_cnt <= CNT_W'(sat_inc(int'(edge_cnt), CNT_MAX));
      end
    end
  end

  assign frame_ok   = sel_rise && (edge_cnt == CNT_W'(WORD_W));
  assign frame_word = rx_sr;
  assign miso_oe    = in_frame;
  assign miso       = in_frame & tx_sr[WORD_W-1];

  // R2: the status word is loaded on the cycle after select falls.
  assert_status_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_fall |=> tx_sr == $past(status_in));

  // R2: each in-frame clock edge moves the status one place toward miso.
  assert_status_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && in_frame && !sel_fall) |=> tx_sr == {$past(tx_sr[WORD_W-2:0]), 1'b0});

  // R4: the edge counter never passes its saturation value.
  assert_cnt_saturates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= CNT_W'(CNT_MAX));

  // R5: while deselected, the receive register does not move.
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ss_s |=> $stable(rx_sr));

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int OP_W   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_ok,
  input  logic [WORD_W-1:0]              frame_word,
  output logic [WORD_W-1:0]              cmd_word,
  output logic                           cmd_valid,
  output logic [(2**(OP_W-1))*(WORD_W-OP_W)-1:0] held_data,
  output logic [2**(OP_W-1)-1:0]         mom_out,
  output logic [WORD_W-OP_W-1:0]         mom_arg
);

  localparam int SLOT_W    = OP_W - 1;
  localparam int NUM_SLOTS = 2 ** SLOT_W;
  localparam int ARG_W     = WORD_W - OP_W;

  logic [OP_W-1:0]   opcode;
  logic [SLOT_W-1:0] slot;
  logic [ARG_W-1:0]  arg;
  cmd_kind_e         kind;
  logic              hit_latched, hit_momentary;

  assign opcode        = frame_word[WORD_W-1 -: OP_W];
  assign slot          = opcode[SLOT_W-1:0];
  assign arg           = frame_word[ARG_W-1:0];
  assign kind          = kind_of(opcode[OP_W-1]);
  assign hit_latched   = frame_ok && (kind == KIND_LATCHED);
  assign hit_momentary = frame_ok && (kind == KIND_MOMENTARY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_word  <= '0;
      cmd_valid <= 1'b0;
      mom_out   <= '0;
      mom_arg   <= '0;
    end else begin
      cmd_valid <= frame_ok;
      if (frame_ok) cmd_word <= frame_word;
      if (hit_momentary) begin
        mom_out <= {{(NUM_SLOTS-1){1'b0}}, 1'b1} << slot;
        mom_arg <= arg;
      end else if (hit_latched) begin
        mom_out <= '0;
      end
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [ARG_W-1:0] held_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                     held_q <= '0;
      else if (hit_latched && slot == SLOT_W'(g))     held_q <= arg;
    end
    assign held_data[g*ARG_W +: ARG_W] = held_q;
  end

  // R3: the strobe is never wider than one cycle.
  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);

  // R3: an accepted frame publishes exactly the received word.
  assert_commit_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> (cmd_valid && cmd_word == $past(frame_word)));

  // R4: without an accepted frame, no decoded output moves.
  assert_no_commit_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_ok |=> ($stable(cmd_word) && $stable(held_data) && $stable(mom_out) && $stable(mom_arg)));

  // R7: at most one momentary line is up.
  assert_mom_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mom_out));

  // R7: a latched command ends any momentary command.
  assert_latched_clears_mom_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_latched |=> mom_out == '0);

endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int WORD_W      = 16,
  parameter int OP_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   ss_n,
  input  logic                                   sclk,
  input  logic                                   mosi,
  output logic                                   miso,
  output logic                                   miso_oe,
  input  logic [WORD_W-1:0]                      status_in,
  output logic [WORD_W-1:0]                      cmd_word,
  output logic                                   cmd_valid,
  output logic [(2**(OP_W-1))*(WORD_W-OP_W)-1:0] held_data,
  output logic [2**(OP_W-1)-1:0]                 mom_out,
  output logic [WORD_W-OP_W-1:0]                 mom_arg
);

  logic              frame_ok;
  logic [WORD_W-1:0] frame_word;

  spi_frame_rx #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .status_in(status_in), .miso(miso), .miso_oe(miso_oe),
    .frame_ok(frame_ok), .frame_word(frame_word));

  spi_cmd_decode #(.WORD_W(WORD_W), .OP_W(OP_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_word(frame_word),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .held_data(held_data),
    .mom_out(mom_out), .mom_arg(mom_arg));

  // R1: the output enable and the data pin never disagree outside a frame.
  assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

endmodule

// File: tb/tb_spi_cmd_slave.sv
module tb_spi_cmd_slave;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ss_n = 1'b1;
  logic        sclk = 1'b0;
  logic        mosi = 1'b0;
  logic [15:0] status_in = '0;
  logic        miso, miso_oe, cmd_valid;
  logic [15:0] cmd_word;
  logic [95:0] held_data;
  logic [7:0]  mom_out;
  logic [11:0] mom_arg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model of the decoded state
  logic [15:0] m_word = '0;
  logic [95:0] m_held = '0;
  logic [7:0]  m_mom  = '0;
  logic [11:0] m_arg  = '0;

  always #5 clk = ~clk;

  spi_cmd_slave dut (
    .clk(clk), .rst_n(rst_n), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status_in(status_in),
    .cmd_word(cmd_word), .cmd_valid(cmd_valid), .held_data(held_data),
    .mom_out(mom_out), .mom_arg(mom_arg));

  task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Three rising edges pass, then sample on the falling edge.
  task automatic wait_result();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hold_phase();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_state(input string req);
    chk(cmd_word == m_word, {req, " cmd_word"}, 96'(cmd_word), 96'(m_word));
    chk(held_data == m_held, {req, " held_data"}, held_data, m_held);
    chk(mom_out == m_mom, {req, " mom_out"}, 96'(mom_out), 96'(m_mom));
    chk(mom_arg == m_arg, {req, " mom_arg"}, 96'(mom_arg), 96'(m_arg));
  endtask

  // One frame of the given edge count; checks miso, oe and the strobe.
  task automatic send_frame(input logic [15:0] word, input int edges, input logic [15:0] status);
    bit accept;
    logic exp_bit;
    accept = (edges == 16);
    status_in = status;
    @(negedge clk);
    ss_n = 1'b0;
    wait_result();
    chk(miso_oe == 1'b1, "R1 oe in frame", 96'(miso_oe), 96'(1));
    chk(miso == status[15], "R2 first status bit", 96'(miso), 96'(status[15]));
    status_in = ~status;   // capture must already be done
    for (int i = 0; i < edges; i++) begin
      mosi = (i < 16) ? word[15-i] : 1'b0;
      hold_phase();
      sclk = 1'b1;
      wait_result();
      exp_bit = (i + 1 < 16) ? status[14-i] : 1'b0;
      chk(miso == exp_bit, "R2 status shift", 96'(miso), 96'(exp_bit));
      sclk = 1'b0;
      hold_phase();
    end
    ss_n = 1'b1;
    wait_result();
    chk(cmd_valid == accept, "R3/R4 strobe", 96'(cmd_valid), 96'(accept));
    chk(miso_oe == 1'b0, "R1 oe after frame", 96'(miso_oe), 96'(0));
    @(negedge clk);
    chk(cmd_valid == 1'b0, "R3 strobe one cycle", 96'(cmd_valid), 96'(0));
    if (accept) begin
      m_word = word;
      if (word[15]) begin
        m_held[int'(word[14:12])*12 +: 12] = word[11:0];
        m_mom = '0;
      end else begin
        m_mom = 8'(1) << word[14:12];
        m_arg = word[11:0];
      end
    end
    hold_phase();
  endtask

  task automatic t_reset();
    chk(cmd_valid == 0 && miso_oe == 0, "R8 reset strobe/oe", 96'({cmd_valid, miso_oe}), 96'(0));
    check_state("R8 reset");
  endtask

  task automatic t_momentary();
    send_frame(16'h3ABC, 16, 16'hA55A);
    chk(mom_out == 8'h08, "R7 momentary line", 96'(mom_out), 96'(8'h08));
    check_state("R3 R7 momentary");
  endtask

  task automatic t_momentary_replace();
    send_frame(16'h6123, 16, 16'h0F0F);
    check_state("R7 replaced");
  endtask

  task automatic t_latched();
    send_frame(16'h9456, 16, 16'hFFFF);
    chk(mom_out == 8'h00, "R7 latched clears", 96'(mom_out), 96'(0));
    send_frame(16'hF7E1, 16, 16'h8001);
    check_state("R6 latched slots");
  endtask

  task automatic t_persist();
    send_frame(16'h0FED, 16, 16'h1234);
    chk(held_data[12 +: 12] == 12'h456, "R6 slot1 persists", 96'(held_data[12 +: 12]), 96'(12'h456));
    check_state("R6 persist");
  endtask

  task automatic t_bad_counts();
    send_frame(16'h2777, 15, 16'h5555);
    check_state("R4 short frame");
    send_frame(16'hA888, 17, 16'hAAAA);
    check_state("R4 long frame");
    send_frame(16'h1999, 48, 16'hC3C3);
    check_state("R4 saturated frame");
  endtask

  task automatic t_deselected();
    for (int i = 0; i < 6; i++) begin
      mosi = i[0];
      hold_phase();
      sclk = 1'b1;
      wait_result();
      chk(miso_oe == 1'b0 && cmd_valid == 1'b0, "R5 idle edge", 96'({miso_oe, cmd_valid}), 96'(0));
      sclk = 1'b0;
      hold_phase();
    end
    check_state("R5 idle activity");
    send_frame(16'hB0C1, 16, 16'h7E7E);
    check_state("R5 frame after idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_momentary();
    t_momentary_replace();
    t_latched();
    t_persist();
    t_bad_counts();
    t_deselected();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule